// File: doc/BRIEF.md
# Match-Set Overflow-Clear 16-bit PWM Channel

This block is one pulse-width channel that follows a free-running 16-bit timebase shared with other channels. The timebase value and a one-cycle wrap strobe come in from outside. The strobe is high in the cycle where the count reads zero just after rolling over. The output rises on the clock after the count equals a 16-bit compare value. It falls on the clock after the wrap strobe. The compare value therefore gives the number of low clocks in each 65536-clock period, and the duty is (65536 − compare) / 65536.

Software loads the compare value one byte at a time on a shared 8-bit data bus. Each byte write also changes the comparator enable: a low-byte write turns it off and a high-byte write turns it on. Software must therefore write the low byte first. A mode write sets the enable and selection bits directly. A sticky match flag and a gated interrupt request let software time its compare updates to the match event.

Top module: `pwm16_match_pwm`

## Requirements
- R1: After reset the output, the match flag and the interrupt request are 0. The compare value is 0x0000 and every mode bit is 0.
- R2: When the enable is 1, PWM output mode is on and tbCount equals the compare value, pwmOut is 1 from the next clock.
- R3: When tbWrap is 1 and there is no enabled match, pwmOut is 0 from the next clock.
- R4: A match and a wrap in the same cycle leave pwmOut at 1, so compare 0x0000 holds the output high continuously (100% duty).
- R5: With a steady timebase, pwmOut is high for exactly 65536 − compare clocks in every period: 65536 for 0x0000, 65535 for 0x0001 and 1 for 0xFFFF.
- R6: A wrLo pulse loads wrData into compare bits 7:0 and clears the enable. While the enable is 0, no match sets the output or the flag, so pwmOut falls at the next wrap and stays low (0% duty).
- R7: A wrHi pulse loads wrData into compare bits 15:8 and sets the enable. The new value is compared from the clock after the write. wrHi wins over wrLo in the same cycle.
- R8: The match flag is set on every enabled match, whatever the output mode. It holds until a flagClr pulse. A match in the same cycle as flagClr leaves the flag set.
- R9: irqReq is 1 exactly when the match flag, the match-event enable and the interrupt enable are all 1.
- R10: A modeWr pulse loads wrData[4:0]: bit 0 is the enable, bit 1 selects PWM, bit 2 selects 16-bit width, bit 3 is the match-event enable and bit 4 is the interrupt enable. PWM output mode is on only when bits 1 and 2 are both 1. Otherwise pwmOut is 0 from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tbCount | input | 16 | Shared timebase count |
| tbWrap | input | 1 | High in the cycle the count has just wrapped to zero |
| wrLo | input | 1 | Write wrData to compare low byte, clears enable |
| wrHi | input | 1 | Write wrData to compare high byte, sets enable |
| modeWr | input | 1 | Write wrData[4:0] to the mode bits |
| wrData | input | 8 | Shared write data |
| flagClr | input | 1 | Write-one-to-clear pulse for the match flag |
| pwmOut | output | 1 | PWM output |
| matchFlag | output | 1 | Sticky match flag |
| irqReq | output | 1 | Match interrupt request |

## Verification
The bench aims at the cycle where match and wrap coincide with compare zero. A design that lets the clear win there would drop the output for one clock per period and never reach 100% duty. It loads a new low byte while the output is high and checks that the output falls at the next wrap and is not set again. A design that missed the side effect of the low-byte write would keep producing pulses. It also checks that a high-byte write takes effect one clock later, not in the same cycle. It checks that a clear arriving with a match leaves the flag set, since otherwise software could lose an event. Full-period counts at compare 0x0001 and 0xFFFF expose off-by-one errors in the set and clear timing.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 5;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic modeLoad;
    logic enLoad;
    logic enVal;
    logic flagClr;
  } ctlStrobes_t;

  typedef struct packed {
    logic irqEn;
    logic evtEn;
    logic wideSel;
    logic pwmSel;
  } modeBits_t;
endpackage

// File: rtl/pwm16_ctrl.sv
module pwm16_ctrl
  import pwm16_pkg::*;
(
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic              modeWr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  output ctlStrobes_t       strb
);
  always_comb begin
    strb          = '0;
    strb.loadLo   = wrLo;
    strb.loadHi   = wrHi;
    strb.modeLoad = modeWr;
    strb.flagClr  = flagClr;
    strb.enLoad   = wrLo | wrHi | modeWr;
    if (wrHi)      strb.enVal = 1'b1;
    else if (wrLo) strb.enVal = 1'b0;
    else           strb.enVal = wrData[0];
  end
endmodule

// File: rtl/pwm16_datapath.sv
module pwm16_datapath
  import pwm16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  tbCount,
  input  logic              tbWrap,
  input  logic [BYTE_W-1:0] wrData,
  input  ctlStrobes_t       strb,
  output logic              pwmOut,
  output logic              matchFlag,
  output logic              irqReq,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              cmpEn,
  output logic              pwmOn
);
  modeBits_t modeQ;
  logic      hit;

  assign hit   = cmpEn && (tbCount == cmpVal);
  assign pwmOn = modeQ.pwmSel && modeQ.wideSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '0;
      cmpEn  <= 1'b0;
      modeQ  <= '0;
    end else begin
      if (strb.loadLo) cmpVal[BYTE_W-1:0]     <= wrData;
      if (strb.loadHi) cmpVal[CNT_W-1:BYTE_W] <= wrData;
      if (strb.enLoad) cmpEn <= strb.enVal;
      if (strb.modeLoad) modeQ <= modeBits_t'(wrData[MODE_W-1:1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pwmOut <= 1'b0;
    else if (!pwmOn)    pwmOut <= 1'b0;
    else if (hit)       pwmOut <= 1'b1;
    else if (tbWrap)    pwmOut <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             matchFlag <= 1'b0;
    else if (hit)          matchFlag <= 1'b1;
    else if (strb.flagClr) matchFlag <= 1'b0;
  end

  assign irqReq = matchFlag && modeQ.evtEn && modeQ.irqEn;
endmodule

// File: rtl/pwm16_match_pwm.sv
module pwm16_match_pwm
  import pwm16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  tbCount,
  input  logic              tbWrap,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic              modeWr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  output logic              pwmOut,
  output logic              matchFlag,
  output logic              irqReq
);
  ctlStrobes_t       strb;
  logic [CNT_W-1:0]  cmpVal;
  logic              cmpEn;
  logic              pwmOn;

  pwm16_ctrl u_ctrl (
    .wrLo(wrLo), .wrHi(wrHi), .modeWr(modeWr), .wrData(wrData),
    .flagClr(flagClr), .strb(strb)
  );

  pwm16_datapath u_dp (
    .clk(clk), .rstN(rstN), .tbCount(tbCount), .tbWrap(tbWrap),
    .wrData(wrData), .strb(strb), .pwmOut(pwmOut), .matchFlag(matchFlag),
    .irqReq(irqReq), .cmpVal(cmpVal), .cmpEn(cmpEn), .pwmOn(pwmOn)
  );
endmodule

// File: rtl/pwm16_checker.sv
module pwm16_checker
  import pwm16_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] tbCount,
  input logic             tbWrap,
  input logic             wrLo,
  input logic             wrHi,
  input logic             flagClr,
  input logic             pwmOut,
  input logic             matchFlag,
  input logic             irqReq,
  input logic [CNT_W-1:0] cmpVal,
  input logic             cmpEn,
  input logic             pwmOn
);
  assert_set_on_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEn && pwmOn && tbCount == cmpVal) |=> pwmOut);

  assert_clear_on_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tbWrap && !(cmpEn && tbCount == cmpVal)) |=> !pwmOut);

  assert_lo_disables_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && !wrHi) |=> !cmpEn);

  assert_hi_enables_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> cmpEn);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEn && tbCount == cmpVal) |=> matchFlag);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !flagClr) |=> matchFlag);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> matchFlag);

  assert_low_when_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pwmOn |=> !pwmOut);
endmodule

bind pwm16_match_pwm pwm16_checker u_chk (
  .clk(clk), .rstN(rstN), .tbCount(tbCount), .tbWrap(tbWrap),
  .wrLo(wrLo), .wrHi(wrHi), .flagClr(flagClr), .pwmOut(pwmOut),
  .matchFlag(matchFlag), .irqReq(irqReq), .cmpVal(cmpVal),
  .cmpEn(cmpEn), .pwmOn(pwmOn)
);

// File: tb/sim_pwm16_match_pwm.sv
module sim_pwm16_match_pwm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tbCount = '0;
  logic        tbWrap = 1'b0;
  logic        wrLo = 1'b0, wrHi = 1'b0, modeWr = 1'b0, flagClr = 1'b0;
  logic [7:0]  wrData = '0;
  logic        pwmOut, matchFlag, irqReq;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  always #2 clk = ~clk;

  pwm16_match_pwm u0 (
    .clk(clk), .rstN(rstN), .tbCount(tbCount), .tbWrap(tbWrap),
    .wrLo(wrLo), .wrHi(wrHi), .modeWr(modeWr), .wrData(wrData),
    .flagClr(flagClr), .pwmOut(pwmOut), .matchFlag(matchFlag), .irqReq(irqReq)
  );

  // op: 0 tick, 1 low byte, 2 high byte, 3 mode, 4 flag clear
  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  data;
    logic [15:0] cnt;
    logic        wrap;
    logic        eOut;
    logic        eFlag;
    logic        eIrq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    '{3'd3, 8'h06, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 mode pwm+wide
    '{3'd1, 8'h10, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{3'd2, 8'h00, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{3'd0, 8'h00, 16'h0010, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 R8
    '{3'd0, 8'h00, 16'h0011, 1'b0, 1'b1, 1'b1, 1'b0},
    '{3'd4, 8'h00, 16'h0012, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 clear
    '{3'd0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{3'd0, 8'h00, 16'h0010, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
    '{3'd1, 8'h20, 16'h0011, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 disable
    '{3'd0, 8'h00, 16'h0020, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 no match
    '{3'd4, 8'h00, 16'h0021, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'd0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 fall at wrap
    '{3'd0, 8'h00, 16'h0020, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 stays low
    '{3'd2, 8'h00, 16'h0020, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 not same cycle
    '{3'd0, 8'h00, 16'h0020, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 next clock
    '{3'd3, 8'h1F, 16'h0030, 1'b0, 1'b1, 1'b1, 1'b1}, // R9
    '{3'd4, 8'h00, 16'h0031, 1'b0, 1'b1, 1'b0, 1'b0}, // R9
    '{3'd4, 8'h00, 16'h0020, 1'b0, 1'b1, 1'b1, 1'b1}, // R8 set wins
    '{3'd1, 8'h00, 16'h0040, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd2, 8'h00, 16'h0041, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd4, 8'h00, 16'h0042, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1}, // R4
    '{3'd4, 8'h00, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'd3, 8'h1D, 16'h0002, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 pwm off
    '{3'd0, 8'h00, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
    '{3'd0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 any mode
    '{3'd3, 8'h0E, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 irq off
    '{3'd4, 8'h00, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}  // R6 0% duty
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] d,
                      input logic [15:0] c, input logic w);
    tbCount = c; tbWrap = w; wrData = d;
    wrLo = (op == 3'd1); wrHi = (op == 3'd2);
    modeWr = (op == 3'd3); flagClr = (op == 3'd4);
    @(posedge clk); @(negedge clk);
    wrLo = 0; wrHi = 0; modeWr = 0; flagClr = 0;
  endtask

  task automatic dutyRun(input logic [15:0] cmp, input string req);
    int high = 0;
    step(3'd1, cmp[7:0], 16'h0100, 1'b0);
    step(3'd2, cmp[15:8], 16'h0101, 1'b0);
    for (int v = 0; v < 65536; v++) begin
      tbCount = v[15:0]; tbWrap = (v == 0);
      @(posedge clk); @(negedge clk);
      if (pwmOut) high++;
    end
    check(req, high, 65536 - int'(cmp));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 out", pwmOut, 0);
    check("R1 flag", matchFlag, 0);
    check("R1 irq", irqReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VT[i].op, VT[i].data, VT[i].cnt, VT[i].wrap);
      check($sformatf("R2-table step %0d out", i), pwmOut, VT[i].eOut);
      check($sformatf("R8 step %0d flag", i), matchFlag, VT[i].eFlag);
      check($sformatf("R9 step %0d irq", i), irqReq, VT[i].eIrq);
    end
    // R5 full-period duty
    step(3'd3, 8'h06, 16'h0100, 1'b0);
    dutyRun(16'h0001, "R5 cmp=0001");
    dutyRun(16'hFFFF, "R5 cmp=FFFF");
    // R1 reset mid-run while output high, then compare value is zero
    step(3'd1, 8'h00, 16'h0200, 1'b0);
    step(3'd2, 8'h00, 16'h0201, 1'b0);
    step(3'd0, 8'h00, 16'h0000, 1'b1);
    check("R4 high at wrap", pwmOut, 1);
    rstN = 1'b0;
    #1;
    check("R1 out after reset", pwmOut, 0);
    check("R1 flag after reset", matchFlag, 0);
    @(negedge clk); rstN = 1'b1; @(negedge clk);
    step(3'd3, 8'h07, 16'h0001, 1'b0);
    step(3'd0, 8'h00, 16'h0000, 1'b1);
    check("R1 compare zero after reset", pwmOut, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule